// File: doc/BRIEF.md
# Flash Command Sequencer with Halt, Retry and Bad-Block Remapping

This block is the command engine between a host and a NAND-style memory array. The host presents read, program and erase requests with a logical address through a valid/ready handshake. The sequencer translates the block part of that address and pulses one array strobe. It then follows the array's ready line until the operation finishes, and reports the result on a one-cycle done pulse with a result code.

Some operations end badly: a read that the error-correction logic flags as uncorrectable, or a program or erase that the array reports as failed. In these cases the sequencer parks in a halted state and keeps the pending request. The host then chooses to retry the request or to abort it. Each logical block has a counter of uncorrectable reads. A block is declared bad when the counter reaches a set limit, or at once when a program or erase fails. A bad block takes the next free spare from a reserve pool that sits above the logical block range. When the pool is empty, the block stays bad, keeps its own address, and a sticky flag reports the exhausted pool.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, hostReady is 1, halted is 0, doneValid is 0, poolEmpty is 0 and no array strobe is active.
- R2: A read (code 1), program (code 2) or erase (code 3) accepted while idle produces the matching strobe (arrRead, arrProg or arrErase) for exactly one cycle, in the cycle after acceptance. hostReady stays 0 until the operation ends.
- R3: An operation completes only after arrReady has been low and is high again. No done pulse appears while arrReady is held low.
- R4: A finished program or erase, or a read without an uncorrectable flag, returns to idle with a one-cycle doneValid. doneCode is 0 for a clean result and 1 for a read with a corrected error.
- R5: An uncorrectable read, or a program or erase that ends with arrFail, enters the halted state (halted = 1, hostReady = 1) with no done pulse.
- R6: While halted, retry (code 4) reissues the saved operation one cycle later. Read, program, erase and no-op (code 0) are consumed without effect.
- R7: Abort (code 5) while halted returns to idle with doneValid and doneCode 2, and drops the saved operation. A later retry while idle produces no strobe.
- R8: arrAddr is {physical block, page}, with the page in the low PAGE_W bits. An erase presents page 0; a read or program presents the host page.
- R9: A logical block becomes bad on its ERR_LIMIT-th uncorrectable read, or on one failed program or erase. A bad block takes spare k, at physical block 2^BLK_W + k, with k counting up from 0 in the order blocks go bad.
- R10: Every later access to a remapped block goes to its spare, including a retry of the request that caused the remap. Blocks that are not bad keep their own number.
- R11: A block that goes bad with no spare left sets poolEmpty, which stays set, and the block keeps its own physical number.
- R12: At most one array strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host request valid |
| hostCmd | input | 3 | Request code: 0 no-op, 1 read, 2 program, 3 erase, 4 retry, 5 abort |
| hostAddr | input | BLK_W+PAGE_W | Logical address {block, page} |
| hostReady | output | 1 | Sequencer can take a request (idle or halted) |
| arrRead | output | 1 | Read strobe to the array |
| arrProg | output | 1 | Program strobe to the array |
| arrErase | output | 1 | Erase strobe to the array |
| arrAddr | output | clog2(2^BLK_W+SPARE_N)+PAGE_W | Translated physical address {block, page} |
| arrReady | input | 1 | Array ready, low while busy |
| eccCorr | input | 1 | Corrected error on the finishing read |
| eccUncorr | input | 1 | Uncorrectable error on the finishing read |
| arrFail | input | 1 | Finishing program or erase failed |
| doneValid | output | 1 | One-cycle completion pulse |
| doneCode | output | 2 | 0 clean, 1 corrected, 2 aborted |
| halted | output | 1 | Sequencer waits for retry or abort |
| poolEmpty | output | 1 | Sticky: a bad block found no spare |

## Verification
Two things happen in one clock edge when a failing operation completes: the entry into the halted state and the bad-block update, which covers the counter step, the spare allocation and the pool-empty flag. The bench provokes this with the limit-reaching uncorrectable read, a failed program, and a failed erase after the pool has run dry. It judges the result from the port side by checking halted and poolEmpty right after the edge. The address shown on the next retry shows whether the remap was already in effect, which it must be: the spare for a new allocation, and the block's own number when the pool is empty.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_PROG  = 3'd2,
    CMD_ERASE = 3'd3,
    CMD_RETRY = 3'd4,
    CMD_ABORT = 3'd5
  } hostCmd_e;

  typedef enum logic [1:0] {
    DONE_OK    = 2'd0,
    DONE_CORR  = 2'd1,
    DONE_ABORT = 2'd2
  } doneCode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_PROG,
    S_ERASE,
    S_HALT
  } seqState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;        // capture host command and address
    logic finishOk;
    logic finishCorr;
    logic finishAbort;
    logic countErr;    // one more uncorrectable read on current block
    logic markBad;     // current block is declared bad
  } pathCtl_t;

endpackage

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic [2:0] hostCmd,
  input  logic [2:0] savedCmd,
  input  logic       arrReady,
  input  logic       eccCorr,
  input  logic       eccUncorr,
  input  logic       arrFail,
  input  logic       errLimitHit,
  output logic       hostReady,
  output logic       arrRead,
  output logic       arrProg,
  output logic       arrErase,
  output logic       halted,
  output pathCtl_t   ctl
);

  seqState_e state, nextState;
  logic issued, started;
  logic accept, opDone, inOp;

  function automatic seqState_e opStateOf(input logic [2:0] cmd);
    case (cmd)
      CMD_READ:  return S_READ;
      CMD_PROG:  return S_PROG;
      CMD_ERASE: return S_ERASE;
      default:   return S_IDLE;
    endcase
  endfunction

  function automatic logic isOpCmd(input logic [2:0] cmd);
    return (cmd == CMD_READ) || (cmd == CMD_PROG) || (cmd == CMD_ERASE);
  endfunction

  assign inOp      = (state == S_READ) || (state == S_PROG) || (state == S_ERASE);
  assign hostReady = (state == S_IDLE) || (state == S_HALT);
  assign halted    = (state == S_HALT);
  assign accept    = hostValid && hostReady;
  assign opDone    = inOp && issued && started && arrReady;

  assign arrRead  = (state == S_READ)  && !issued;
  assign arrProg  = (state == S_PROG)  && !issued;
  assign arrErase = (state == S_ERASE) && !issued;

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      S_IDLE: begin
        if (accept && isOpCmd(hostCmd)) begin
          ctl.load  = 1'b1;
          nextState = opStateOf(hostCmd);
        end
      end
      S_HALT: begin
        if (accept && hostCmd == CMD_RETRY && isOpCmd(savedCmd)) begin
          nextState = opStateOf(savedCmd);
        end else if (accept && hostCmd == CMD_ABORT) begin
          ctl.finishAbort = 1'b1;
          nextState       = S_IDLE;
        end
      end
      S_READ: begin
        if (opDone) begin
          if (eccUncorr) begin
            ctl.countErr = 1'b1;
            ctl.markBad  = errLimitHit;
            nextState    = S_HALT;
          end else begin
            ctl.finishCorr = eccCorr;
            ctl.finishOk   = !eccCorr;
            nextState      = S_IDLE;
          end
        end
      end
      S_PROG, S_ERASE: begin
        if (opDone) begin
          if (arrFail) begin
            ctl.markBad = 1'b1;
            nextState   = S_HALT;
          end else begin
            ctl.finishOk = 1'b1;
            nextState    = S_IDLE;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      issued  <= 1'b0;
      started <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        issued  <= 1'b0;
        started <= 1'b0;
      end else if (inOp) begin
        issued <= 1'b1;
        if (!arrReady) started <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fsq_path.sv
module fsq_path
  import fsq_pkg::*;
#(
  parameter int BLK_W     = 3,
  parameter int PAGE_W    = 2,
  parameter int SPARE_N   = 2,
  parameter int ERR_LIMIT = 2,
  localparam int NBLK     = 1 << BLK_W,
  localparam int PBLK_W   = $clog2(NBLK + SPARE_N),
  localparam int HA_W     = BLK_W + PAGE_W,
  localparam int PA_W     = PBLK_W + PAGE_W
)(
  input  logic            clk,
  input  logic            rstN,
  input  pathCtl_t        ctl,
  input  logic [2:0]      hostCmd,
  input  logic [HA_W-1:0] hostAddr,
  output logic [2:0]      savedCmd,
  output logic [PA_W-1:0] arrAddr,
  output logic            errLimitHit,
  output logic            doneValid,
  output logic [1:0]      doneCode,
  output logic            poolEmpty
);

  localparam int SIW = (SPARE_N > 1) ? $clog2(SPARE_N) : 1;
  localparam int CW  = $clog2(SPARE_N + 1);
  localparam int EW  = $clog2(ERR_LIMIT + 1);

  logic [HA_W-1:0]   savedAddr;
  logic [BLK_W-1:0]  curBlk;
  logic [PAGE_W-1:0] curPage;
  logic [NBLK-1:0]   badMap;
  logic [NBLK-1:0]   mapValid;
  logic [SIW-1:0]    mapIdx [NBLK];
  logic [EW-1:0]     errCnt [NBLK];
  logic [CW-1:0]     spareUsed;
  logic              spareLeft, newBad, takeSpare;
  logic [PBLK_W-1:0] physBlk;

  assign curBlk  = savedAddr[HA_W-1:PAGE_W];
  assign curPage = savedAddr[PAGE_W-1:0];

  assign spareLeft   = (spareUsed < CW'(SPARE_N));
  assign newBad      = ctl.markBad && !badMap[curBlk];
  assign takeSpare   = newBad && spareLeft;
  assign errLimitHit = (errCnt[curBlk] == EW'(ERR_LIMIT - 1));

  // address translation through the remap table
  assign physBlk = mapValid[curBlk] ? (PBLK_W'(NBLK) + PBLK_W'(mapIdx[curBlk]))
                                    : PBLK_W'(curBlk);
  assign arrAddr = {physBlk, (savedCmd == CMD_ERASE) ? PAGE_W'(0) : curPage};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedCmd  <= CMD_NOP;
      savedAddr <= '0;
    end else if (ctl.load) begin
      savedCmd  <= hostCmd;
      savedAddr <= hostAddr;
    end else if (ctl.finishAbort) begin
      savedCmd  <= CMD_NOP;
    end
  end

  // per-block health and remap state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      badMap   <= '0;
      mapValid <= '0;
      for (int b = 0; b < NBLK; b++) begin
        mapIdx[b] <= '0;
        errCnt[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NBLK; b++) begin
        if (curBlk == BLK_W'(b)) begin
          if (ctl.countErr && !badMap[b] && errCnt[b] != EW'(ERR_LIMIT))
            errCnt[b] <= errCnt[b] + EW'(1);
          if (ctl.markBad)
            badMap[b] <= 1'b1;
          if (takeSpare) begin
            mapValid[b] <= 1'b1;
            mapIdx[b]   <= SIW'(spareUsed);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spareUsed <= '0;
      poolEmpty <= 1'b0;
    end else begin
      if (takeSpare)            spareUsed <= spareUsed + CW'(1);
      if (newBad && !spareLeft) poolEmpty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneCode  <= DONE_OK;
    end else begin
      doneValid <= ctl.finishOk || ctl.finishCorr || ctl.finishAbort;
      if (ctl.finishAbort)     doneCode <= DONE_ABORT;
      else if (ctl.finishCorr) doneCode <= DONE_CORR;
      else if (ctl.finishOk)   doneCode <= DONE_OK;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fsq_pkg::*;
#(
  parameter int BLK_W     = 3,
  parameter int PAGE_W    = 2,
  parameter int SPARE_N   = 2,
  parameter int ERR_LIMIT = 2
)(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hostValid,
  input  logic [2:0]                hostCmd,
  input  logic [BLK_W+PAGE_W-1:0]   hostAddr,
  output logic                      hostReady,
  output logic                      arrRead,
  output logic                      arrProg,
  output logic                      arrErase,
  output logic [$clog2((1<<BLK_W)+SPARE_N)+PAGE_W-1:0] arrAddr,
  input  logic                      arrReady,
  input  logic                      eccCorr,
  input  logic                      eccUncorr,
  input  logic                      arrFail,
  output logic                      doneValid,
  output logic [1:0]                doneCode,
  output logic                      halted,
  output logic                      poolEmpty
);

  pathCtl_t   ctl;
  logic [2:0] savedCmd;
  logic       errLimitHit;

  fsq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostValid  (hostValid),
    .hostCmd    (hostCmd),
    .savedCmd   (savedCmd),
    .arrReady   (arrReady),
    .eccCorr    (eccCorr),
    .eccUncorr  (eccUncorr),
    .arrFail    (arrFail),
    .errLimitHit(errLimitHit),
    .hostReady  (hostReady),
    .arrRead    (arrRead),
    .arrProg    (arrProg),
    .arrErase   (arrErase),
    .halted     (halted),
    .ctl        (ctl)
  );

  fsq_path #(
    .BLK_W    (BLK_W),
    .PAGE_W   (PAGE_W),
    .SPARE_N  (SPARE_N),
    .ERR_LIMIT(ERR_LIMIT)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .hostCmd    (hostCmd),
    .hostAddr   (hostAddr),
    .savedCmd   (savedCmd),
    .arrAddr    (arrAddr),
    .errLimitHit(errLimitHit),
    .doneValid  (doneValid),
    .doneCode   (doneCode),
    .poolEmpty  (poolEmpty)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int PAGE_W = 2,
  parameter int PA_W   = 6
)(
  input logic            clk,
  input logic            rstN,
  input logic            hostReady,
  input logic            halted,
  input logic            arrRead,
  input logic            arrProg,
  input logic            arrErase,
  input logic [PA_W-1:0] arrAddr,
  input logic            doneValid,
  input logic [1:0]      doneCode,
  input logic            poolEmpty
);

  logic anyStrobe;
  assign anyStrobe = arrRead || arrProg || arrErase;

  assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrRead, arrProg, arrErase}));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !anyStrobe);

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> !hostReady);

  assert_no_early_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !doneValid);

  assert_done_code_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneCode != 2'd3));

  assert_halt_accepts_R5: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (hostReady && !anyStrobe));

  assert_done_leaves_halt_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !halted);

  assert_erase_page_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    arrErase |-> (arrAddr[PAGE_W-1:0] == '0));

  assert_pool_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    poolEmpty |=> poolEmpty);

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .PAGE_W(PAGE_W),
  .PA_W  ($clog2((1<<BLK_W)+SPARE_N)+PAGE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostReady(hostReady),
  .halted   (halted),
  .arrRead  (arrRead),
  .arrProg  (arrProg),
  .arrErase (arrErase),
  .arrAddr  (arrAddr),
  .doneValid(doneValid),
  .doneCode (doneCode),
  .poolEmpty(poolEmpty)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;

  localparam int BLK_W = 3, PAGE_W = 2, SPARE_N = 2, ERR_LIMIT = 2;
  localparam int NBLK = 1 << BLK_W;
  localparam int PA_W = $clog2(NBLK + SPARE_N) + PAGE_W;
  localparam int C_NOP = 0, C_RD = 1, C_PG = 2, C_ER = 3, C_RETRY = 4, C_ABORT = 5;

  logic clk = 1'b0;
  logic rstN;
  logic hostValid;
  logic [2:0] hostCmd;
  logic [BLK_W+PAGE_W-1:0] hostAddr;
  logic hostReady, arrRead, arrProg, arrErase;
  logic [PA_W-1:0] arrAddr;
  logic arrReady, eccCorr, eccUncorr, arrFail;
  logic doneValid;
  logic [1:0] doneCode;
  logic halted, poolEmpty;

  always #2 clk = ~clk;

  flash_cmd_seq #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .SPARE_N(SPARE_N), .ERR_LIMIT(ERR_LIMIT)) dut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostCmd(hostCmd), .hostAddr(hostAddr),
    .hostReady(hostReady), .arrRead(arrRead), .arrProg(arrProg), .arrErase(arrErase),
    .arrAddr(arrAddr), .arrReady(arrReady), .eccCorr(eccCorr), .eccUncorr(eccUncorr),
    .arrFail(arrFail), .doneValid(doneValid), .doneCode(doneCode), .halted(halted),
    .poolEmpty(poolEmpty)
  );

  int tests = 0, failed = 0;
  int spareOf [NBLK];
  int errSeen [NBLK];
  bit badBlk  [NBLK];
  int nextK = 0;
  bit poolExp = 0;
  int savedKind = 0, savedBlk = 0, savedPage = 0;
  bit timedOut = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int strobeCode();
    return int'(arrRead) + 2 * int'(arrProg) + 4 * int'(arrErase);
  endfunction

  function automatic int expStrobe(input int kind);
    return (kind == C_RD) ? 1 : (kind == C_PG) ? 2 : 4;
  endfunction

  function automatic int expAddr(input int kind, input int blk, input int page);
    int phys = (spareOf[blk] >= 0) ? NBLK + spareOf[blk] : blk;
    int pg = (kind == C_ER) ? 0 : page;
    return phys * (1 << PAGE_W) + pg;
  endfunction

  task automatic markModel(input int blk);
    if (!badBlk[blk]) begin
      badBlk[blk] = 1;
      if (nextK < SPARE_N) begin spareOf[blk] = nextK; nextK++; end
      else poolExp = 1;
    end
  endtask

  // one full operation: new command (cmd 1..3) or retry (cmd 4)
  task automatic runOp(input int cmd, input int blk, input int page, input int lat,
                       input bit corr, input bit uncorr, input bit fail, input string req);
    bit expHalt;
    if (cmd != C_RETRY) begin savedKind = cmd; savedBlk = blk; savedPage = page; end
    @(negedge clk);
    hostValid = 1'b1; hostCmd = 3'(cmd); hostAddr = (BLK_W+PAGE_W)'(blk * (1 << PAGE_W) + page);
    @(negedge clk);
    hostValid = 1'b0;
    chk({req, " R2 R12 strobe"}, strobeCode(), expStrobe(savedKind));
    chk({req, " R8 R10 address"}, int'(arrAddr), expAddr(savedKind, savedBlk, savedPage));
    chk({req, " R2 busy"}, int'(hostReady), 0);
    arrReady = 1'b0;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      if (i == 0) chk({req, " R2 single strobe"}, strobeCode(), 0);
      chk({req, " R3 no done while busy"}, int'(doneValid), 0);
    end
    arrReady  = 1'b1;
    eccCorr   = corr   && savedKind == C_RD;
    eccUncorr = uncorr && savedKind == C_RD;
    arrFail   = fail   && savedKind != C_RD;
    @(negedge clk);
    eccCorr = 1'b0; eccUncorr = 1'b0; arrFail = 1'b0;
    expHalt = (savedKind == C_RD) ? uncorr : fail;
    if (savedKind == C_RD && uncorr && !badBlk[savedBlk]) begin
      errSeen[savedBlk]++;
      if (errSeen[savedBlk] == ERR_LIMIT) markModel(savedBlk);
    end
    if (savedKind != C_RD && fail) markModel(savedBlk);
    if (expHalt) begin
      chk({req, " R5 halted"}, int'(halted), 1);
      chk({req, " R5 no done"}, int'(doneValid), 0);
      chk({req, " R5 ready in halt"}, int'(hostReady), 1);
    end else begin
      chk({req, " R4 done"}, int'(doneValid), 1);
      chk({req, " R4 code"}, int'(doneCode), (savedKind == C_RD && corr) ? 1 : 0);
      chk({req, " R4 not halted"}, int'(halted), 0);
    end
    chk({req, " R11 pool flag"}, int'(poolEmpty), int'(poolExp));
  endtask

  task automatic sendIgnored(input int cmd, input int expHalted, input string req);
    @(negedge clk);
    hostValid = 1'b1; hostCmd = 3'(cmd); hostAddr = '0;
    @(negedge clk);
    hostValid = 1'b0;
    chk({req, " ignored: no strobe"}, strobeCode(), 0);
    chk({req, " ignored: state"}, int'(halted), expHalted);
    chk({req, " ignored: no done"}, int'(doneValid), 0);
    @(negedge clk);
    chk({req, " ignored: still no strobe"}, strobeCode(), 0);
  endtask

  task automatic sendAbort();
    @(negedge clk);
    hostValid = 1'b1; hostCmd = 3'(C_ABORT); hostAddr = '0;
    @(negedge clk);
    hostValid = 1'b0;
    chk("R7 abort done", int'(doneValid), 1);
    chk("R7 abort code", int'(doneCode), 2);
    chk("R7 abort leaves halt", int'(halted), 0);
    @(negedge clk);
    chk("R7 done is one cycle", int'(doneValid), 0);
  endtask

  task automatic mainFlow();
    rstN = 1'b0; hostValid = 1'b0; hostCmd = '0; hostAddr = '0;
    arrReady = 1'b1; eccCorr = 1'b0; eccUncorr = 1'b0; arrFail = 1'b0;
    for (int b = 0; b < NBLK; b++) begin spareOf[b] = -1; errSeen[b] = 0; badBlk[b] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 hostReady", int'(hostReady), 1);
    chk("R1 halted", int'(halted), 0);
    chk("R1 done", int'(doneValid), 0);
    chk("R1 poolEmpty", int'(poolEmpty), 0);
    chk("R1 strobes", strobeCode(), 0);

    // sweep every block, page and operation on a healthy array
    for (int b = 0; b < NBLK; b++)
      for (int p = 0; p < (1 << PAGE_W); p++)
        for (int c = C_RD; c <= C_ER; c++)
          runOp(c, b, p, 1 + ((b + p + c) % 3), p[0], 1'b0, 1'b0, "R4 sweep");

    // first uncorrectable read on block 2: halt, no remap yet
    runOp(C_RD, 2, 1, 2, 1'b0, 1'b1, 1'b0, "R5 uncorr");
    sendIgnored(C_RD, 1, "R6 read in halt");
    sendIgnored(C_NOP, 1, "R6 nop in halt");
    runOp(C_RETRY, 0, 0, 2, 1'b0, 1'b0, 1'b0, "R6 retry below limit R9");

    // second uncorrectable read reaches the limit: spare 0
    runOp(C_RD, 2, 1, 1, 1'b0, 1'b1, 1'b0, "R9 limit reached");
    runOp(C_RETRY, 0, 0, 3, 1'b1, 1'b0, 1'b0, "R10 retry to spare");

    // program failure on block 5: spare 1, then abort
    runOp(C_PG, 5, 3, 1, 1'b0, 1'b0, 1'b1, "R9 program fail");
    sendAbort();
    sendIgnored(C_RETRY, 0, "R7 retry after abort");
    runOp(C_RD, 5, 2, 2, 1'b0, 1'b0, 1'b0, "R10 later read");

    // erase failure with no spare left
    runOp(C_ER, 6, 2, 2, 1'b0, 1'b0, 1'b1, "R11 pool exhausted");
    sendIgnored(C_PG, 1, "R6 program in halt");
    runOp(C_RETRY, 0, 0, 1, 1'b0, 1'b0, 1'b0, "R11 retry keeps own block");

    // mixed traffic after remapping
    runOp(C_RD, 3, 3, 1, 1'b0, 1'b0, 1'b0, "R10 untouched block");
    runOp(C_PG, 2, 2, 2, 1'b0, 1'b0, 1'b0, "R10 spare program");
    runOp(C_ER, 5, 1, 3, 1'b0, 1'b0, 1'b0, "R8 R10 spare erase");
    runOp(C_PG, 1, 0, 1, 1'b0, 1'b0, 1'b1, "R11 second empty-pool mark");
    sendAbort();
    runOp(C_RD, 1, 1, 2, 1'b1, 1'b0, 1'b0, "R11 bad block own address");
  endtask

  initial begin
    fork
      mainFlow();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      tests++; failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule